// File: doc/BRIEF.md
# External Bus Read Sequencer

This block turns single read requests from an on-chip host into read cycles on a parallel bus to asynchronous memory. The bus has a 19-bit address, a 16-bit data input, one active-low chip-select per zone, an active-low read strobe, an active-low write strobe, a read/write direction line and an optional ready input. Each read runs through three phases in a fixed order: lead, then active, then trail. Each zone has its own length for each phase, counted in cycles of the timing clock.

The host offers a request with a valid/ready handshake that carries a zone index and an address. The captured data comes back with a done pulse that lasts one cycle. The block also drives a bus clock. This clock either follows the timing clock or runs at half its rate. In half-rate mode every access must start just after a rising edge of the bus clock. When an access would start off that edge, the block inserts one idle alignment cycle first. The address bus keeps the last address driven whenever no access is on the bus. The ready input can be switched on or off for each zone.

Top module: `xbus_rd_seq`

## Requirements
- R1: After reset, req_ready is 1, every chip-select and both strobes are high (inactive), and bus_addr is 0. req_ready is 1 only while no access is running, and a request is accepted on a clock edge where req_valid and req_ready are both 1.
- R2: For the accepted zone z, chip-select bus_cs_n[z] is low from the first lead cycle through the last trail cycle. Every other chip-select stays high, so at most one chip-select is low at any time.
- R3: The phase lengths of zone z sit in bits [3z+2:3z] of zone_lead, zone_active and zone_trail. A length field of 0 is treated as 1. The lead phase lasts that many cycles, and so do the active phase (when not extended) and the trail phase.
- R4: bus_rd_n is low exactly during the active phase cycles and high in every other cycle.
- R5: With half_rate=0, bus_clk equals the timing clock. With half_rate=1, bus_clk is a divided clock that is 0 after reset and toggles every timing-clock cycle. Every lead phase then starts in a cycle where bus_clk is high.
- R6: In half-rate mode, if the cycle after acceptance would have bus_clk low, exactly one alignment cycle is inserted before the lead phase. During that cycle all chip-selects and strobes are high. In full-rate mode no alignment cycle is ever inserted.
- R7: bus_addr takes the new address in the first lead cycle. It keeps its last value through idle and alignment cycles.
- R8: When bit z of zone_use_rdy is 0, bus_ready has no effect on an access to zone z.
- R9: When bit z of zone_use_rdy is 1, bus_ready passes through a two-flop synchroniser. The active phase is extended one cycle at a time while the synchronised ready is 0 in its last cycle.
- R10: bus_din is captured on the clock edge where bus_rd_n returns high. done is 1 for exactly the first trail cycle, and done_data holds the captured word during that cycle.
- R11: bus_we_n and bus_rnw stay at 1 (write strobe inactive, direction read) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_rate | input | 1 | 1: bus clock runs at half the timing-clock rate |
| zone_lead | input | 3*NZONE | Lead length for each zone, 3 bits per zone |
| zone_active | input | 3*NZONE | Active length for each zone, 3 bits per zone |
| zone_trail | input | 3*NZONE | Trail length for each zone, 3 bits per zone |
| zone_use_rdy | input | NZONE | Per-zone enable for the ready input |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can accept a request |
| req_zone | input | log2(NZONE) | Zone of the request |
| req_addr | input | 19 | Word address of the request |
| done | output | 1 | One-cycle pulse: read complete |
| done_data | output | 16 | Captured read data |
| bus_clk | output | 1 | Bus output clock |
| bus_addr | output | 19 | Bus address |
| bus_cs_n | output | NZONE | Active-low zone chip-selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_we_n | output | 1 | Active-low write strobe (always inactive) |
| bus_rnw | output | 1 | Direction line, 1 = read |
| bus_din | input | 16 | Read data from memory |
| bus_ready | input | 1 | Asynchronous ready from memory |

## Verification
Take the acceptance edge as cycle 0, and let the alignment cycle count as a = 0 or 1. Then the done pulse falls in cycle a+L+A+1, and req_ready comes back T cycles after done. With the ready input enabled and ready raised in cycle r, the active phase ends in cycle max(a+L+A, r+2), because of the two synchroniser flops. The bench keeps a behavioural model that steps on every rising edge and compares every output at the falling edge that follows. The read task measures these latencies in falling edges counted from acceptance, and it works out a from the level of bus_clk in the acceptance cycle.

// File: rtl/xbus_rd_pkg.sv
package xbus_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_LEAD,
        ST_ACTIVE,
        ST_TRAIL
    } seq_state_e;

endpackage

// File: rtl/xbus_busclk_gen.sv
module xbus_busclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic half_rate,
    output logic phase_hi,
    output logic bus_clk
);

    logic phase_d, phase_q;

    always_comb begin
        phase_d = ~phase_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    assign phase_hi = phase_q;
    assign bus_clk  = half_rate ? phase_q : clk;

endmodule

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = async_in;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_out = sh_q[STAGES-1];

endmodule

// File: rtl/xbus_zone_cfg_sel.sv
module xbus_zone_cfg_sel #(
    parameter int NZONE = 4,
    parameter int PH_W  = 3,
    localparam int ZW   = (NZONE > 1) ? $clog2(NZONE) : 1
) (
    input  logic [NZONE*PH_W-1:0] lead_vec,
    input  logic [NZONE*PH_W-1:0] active_vec,
    input  logic [NZONE*PH_W-1:0] trail_vec,
    input  logic [NZONE-1:0]      use_rdy_vec,
    input  logic [ZW-1:0]         zone,
    output logic [PH_W-1:0]       lead_len,
    output logic [PH_W-1:0]       active_len,
    output logic [PH_W-1:0]       trail_len,
    output logic                  use_rdy
);

    logic [PH_W-1:0] lead_arr   [NZONE];
    logic [PH_W-1:0] active_arr [NZONE];
    logic [PH_W-1:0] trail_arr  [NZONE];

    // a zero field is promoted to a one-cycle phase
    function automatic logic [PH_W-1:0] clamp_len(input logic [PH_W-1:0] f);
        return (f == '0) ? PH_W'(1) : f;
    endfunction

    generate
        for (genvar z = 0; z < NZONE; z++) begin : g_zone
            assign lead_arr[z]   = clamp_len(lead_vec[z*PH_W +: PH_W]);
            assign active_arr[z] = clamp_len(active_vec[z*PH_W +: PH_W]);
            assign trail_arr[z]  = clamp_len(trail_vec[z*PH_W +: PH_W]);
        end
    endgenerate

    assign lead_len   = lead_arr[zone];
    assign active_len = active_arr[zone];
    assign trail_len  = trail_arr[zone];
    assign use_rdy    = use_rdy_vec[zone];

endmodule

// File: rtl/xbus_rd_seq.sv
module xbus_rd_seq
    import xbus_rd_pkg::*;
#(
    parameter int NZONE     = 4,
    parameter int AW        = 19,
    parameter int DW        = 16,
    parameter int PH_W      = 3,
    parameter int RDY_SYNC  = 2,
    localparam int ZW       = (NZONE > 1) ? $clog2(NZONE) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  half_rate,
    input  logic [NZONE*PH_W-1:0] zone_lead,
    input  logic [NZONE*PH_W-1:0] zone_active,
    input  logic [NZONE*PH_W-1:0] zone_trail,
    input  logic [NZONE-1:0]      zone_use_rdy,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ZW-1:0]         req_zone,
    input  logic [AW-1:0]         req_addr,
    output logic                  done,
    output logic [DW-1:0]         done_data,
    output logic                  bus_clk,
    output logic [AW-1:0]         bus_addr,
    output logic [NZONE-1:0]      bus_cs_n,
    output logic                  bus_rd_n,
    output logic                  bus_we_n,
    output logic                  bus_rnw,
    input  logic [DW-1:0]         bus_din,
    input  logic                  bus_ready
);

    typedef struct packed {
        seq_state_e      state;
        logic [PH_W-1:0] cnt;
        logic [ZW-1:0]   zone;
        logic [AW-1:0]   pend_addr;
        logic [AW-1:0]   addr;
        logic [PH_W-1:0] lead;
        logic [PH_W-1:0] act;
        logic [PH_W-1:0] trail;
        logic            use_rdy;
        logic [DW-1:0]   data;
        logic            done;
    } seq_t;

    seq_t s_d, s_q;

    logic            phase_hi;
    logic            rdy_sync;
    logic [PH_W-1:0] cfg_lead, cfg_act, cfg_trail;
    logic            cfg_use_rdy;
    logic            in_access;

    xbus_busclk_gen u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_rate (half_rate),
        .phase_hi  (phase_hi),
        .bus_clk   (bus_clk)
    );

    xbus_rdy_sync #(.STAGES(RDY_SYNC)) u_rdy_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_ready),
        .sync_out (rdy_sync)
    );

    xbus_zone_cfg_sel #(.NZONE(NZONE), .PH_W(PH_W)) u_cfg_sel (
        .lead_vec    (zone_lead),
        .active_vec  (zone_active),
        .trail_vec   (zone_trail),
        .use_rdy_vec (zone_use_rdy),
        .zone        (req_zone),
        .lead_len    (cfg_lead),
        .active_len  (cfg_act),
        .trail_len   (cfg_trail),
        .use_rdy     (cfg_use_rdy)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.zone      = req_zone;
                    s_d.pend_addr = req_addr;
                    s_d.lead      = cfg_lead;
                    s_d.act       = cfg_act;
                    s_d.trail     = cfg_trail;
                    s_d.use_rdy   = cfg_use_rdy;
                    s_d.cnt       = '0;
                    // divider flips each edge: high now means low next cycle
                    if (half_rate && phase_hi) begin
                        s_d.state = ST_ALIGN;
                    end else begin
                        s_d.state = ST_LEAD;
                        s_d.addr  = req_addr;
                    end
                end
            end
            ST_ALIGN: begin
                s_d.state = ST_LEAD;
                s_d.addr  = s_q.pend_addr;
                s_d.cnt   = '0;
            end
            ST_LEAD: begin
                if (s_q.cnt == s_q.lead - PH_W'(1)) begin
                    s_d.state = ST_ACTIVE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + PH_W'(1);
                end
            end
            ST_ACTIVE: begin
                if (s_q.cnt >= s_q.act - PH_W'(1)) begin
                    if (!(s_q.use_rdy && !rdy_sync)) begin
                        s_d.state = ST_TRAIL;
                        s_d.cnt   = '0;
                        s_d.data  = bus_din;
                        s_d.done  = 1'b1;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + PH_W'(1);
                end
            end
            ST_TRAIL: begin
                if (s_q.cnt == s_q.trail - PH_W'(1)) begin
                    s_d.state = ST_IDLE;
                    s_d.cnt   = '0;
                end else begin
                    s_d.cnt = s_q.cnt + PH_W'(1);
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_access = (s_q.state == ST_LEAD) || (s_q.state == ST_ACTIVE) ||
                       (s_q.state == ST_TRAIL);

    generate
        for (genvar z = 0; z < NZONE; z++) begin : g_cs
            assign bus_cs_n[z] = !(in_access && (s_q.zone == ZW'(z)));
        end
    endgenerate

    assign req_ready = (s_q.state == ST_IDLE);
    assign bus_rd_n  = (s_q.state != ST_ACTIVE);
    assign bus_addr  = s_q.addr;
    assign done      = s_q.done;
    assign done_data = s_q.data;
    assign bus_we_n  = 1'b1;
    assign bus_rnw   = 1'b1;

endmodule

// File: rtl/xbus_rd_seq_chk.sv
module xbus_rd_seq_chk #(
    parameter int NZONE = 4,
    parameter int AW    = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             half_rate,
    input logic             req_ready,
    input logic             done,
    input logic             bus_clk,
    input logic [AW-1:0]    bus_addr,
    input logic [NZONE-1:0] bus_cs_n,
    input logic             bus_rd_n,
    input logic             bus_we_n,
    input logic             bus_rnw
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&bus_cs_n) && bus_rd_n);

    p_cs_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    p_rd_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !(&bus_cs_n));

    p_lead_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_rate && $fell(&bus_cs_n)) |-> bus_clk);

    p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((&bus_cs_n) && $past(&bus_cs_n)) |-> $stable(bus_addr));

    p_done_at_rd_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bus_rd_n && $past(!bus_rd_n));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_read_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_n && bus_rnw);

endmodule

bind xbus_rd_seq xbus_rd_seq_chk #(.NZONE(NZONE), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_rate (half_rate),
    .req_ready (req_ready),
    .done      (done),
    .bus_clk   (bus_clk),
    .bus_addr  (bus_addr),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_we_n  (bus_we_n),
    .bus_rnw   (bus_rnw)
);

// File: tb/xbus_rd_seq_tb_top.sv
module xbus_rd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NZ = 4;
    localparam int AW = 19;
    localparam int DW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            half_rate = 1'b0;
    // zone3 L2 A3 T4, zone2 all 0, zone1 L3 A5 T2, zone0 L1 A1 T1
    logic [NZ*3-1:0] zone_lead   = {3'd2, 3'd0, 3'd3, 3'd1};
    logic [NZ*3-1:0] zone_active = {3'd3, 3'd0, 3'd5, 3'd1};
    logic [NZ*3-1:0] zone_trail  = {3'd4, 3'd0, 3'd2, 3'd1};
    logic [NZ-1:0]   zone_use_rdy = 4'b1000;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [1:0]      req_zone = '0;
    logic [AW-1:0]   req_addr = '0;
    logic            done;
    logic [DW-1:0]   done_data;
    logic            bus_clk;
    logic [AW-1:0]   bus_addr;
    logic [NZ-1:0]   bus_cs_n;
    logic            bus_rd_n, bus_we_n, bus_rnw;
    logic [DW-1:0]   bus_din;
    logic            bus_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return a[15:0] ^ {a[18:16], 13'h0A5C} ^ 16'h3C96;
    endfunction

    assign bus_din = mem_word(bus_addr);

    xbus_rd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .half_rate(half_rate),
        .zone_lead(zone_lead), .zone_active(zone_active), .zone_trail(zone_trail),
        .zone_use_rdy(zone_use_rdy),
        .req_valid(req_valid), .req_ready(req_ready), .req_zone(req_zone),
        .req_addr(req_addr), .done(done), .done_data(done_data),
        .bus_clk(bus_clk), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
        .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n), .bus_rnw(bus_rnw),
        .bus_din(bus_din), .bus_ready(bus_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int plen(input logic [NZ*3-1:0] v, input int z);
        int f;
        f = int'(v[3*z +: 3]);
        return (f == 0) ? 1 : f;
    endfunction

    // ---------------- behavioural reference model ----------------
    // phase: 0 idle, 1 align, 2 lead, 3 active, 4 trail
    int            m_ph, m_left, m_zone, m_trail, m_act_left;
    bit            m_ur, m_div, m_s1, m_s2, m_done;
    logic [AW-1:0] m_addr, m_pend;
    logic [DW-1:0] m_data;
    int            m_lead_len, m_act_len;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_zone = 0; m_ur = 0; m_div = 0;
            m_s1 = 0; m_s2 = 0; m_done = 0; m_addr = '0; m_pend = '0; m_data = '0;
        end else begin
            m_done = 0;
            case (m_ph)
                0: if (req_valid) begin
                    m_zone = int'(req_zone);
                    m_pend = req_addr;
                    m_lead_len = plen(zone_lead, m_zone);
                    m_act_len  = plen(zone_active, m_zone);
                    m_trail    = plen(zone_trail, m_zone);
                    m_ur       = zone_use_rdy[m_zone];
                    m_left     = m_lead_len;
                    if (half_rate && m_div) m_ph = 1;
                    else begin m_ph = 2; m_addr = req_addr; end
                end
                1: begin m_ph = 2; m_addr = m_pend; end
                2: begin
                    m_left--;
                    if (m_left == 0) begin m_ph = 3; m_left = m_act_len; end
                end
                3: begin
                    if (m_left > 1) m_left--;
                    else if (!(m_ur && !m_s2)) begin
                        m_ph = 4; m_left = m_trail;
                        m_data = mem_word(m_addr); m_done = 1;
                    end
                end
                4: begin
                    m_left--;
                    if (m_left == 0) m_ph = 0;
                end
                default: m_ph = 0;
            endcase
            m_s2 = m_s1;
            m_s1 = bus_ready;
            m_div = !m_div;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [NZ-1:0] e_cs;
            bit ok;
            e_cs = '1;
            if (m_ph >= 2) e_cs[m_zone] = 1'b0;
            ok = 1;
            if (req_ready !== (m_ph == 0)) begin
                ok = 0; $display("FAIL R1 req_ready: actual %0b expected %0b", req_ready, m_ph == 0);
            end
            if (bus_cs_n !== e_cs) begin
                ok = 0; $display("FAIL R2 bus_cs_n: actual %0h expected %0h", bus_cs_n, e_cs);
            end
            if (bus_rd_n !== (m_ph != 3)) begin
                ok = 0; $display("FAIL R4 bus_rd_n: actual %0b expected %0b", bus_rd_n, m_ph != 3);
            end
            if (bus_clk !== (half_rate ? m_div : 1'b0)) begin
                ok = 0; $display("FAIL R5 bus_clk: actual %0b expected %0b", bus_clk, half_rate ? m_div : 1'b0);
            end
            if (bus_addr !== m_addr) begin
                ok = 0; $display("FAIL R7 bus_addr: actual %0h expected %0h", bus_addr, m_addr);
            end
            if (done !== m_done || (m_done && done_data !== m_data)) begin
                ok = 0; $display("FAIL R10 done/data: actual %0b/%0h expected %0b/%0h", done, done_data, m_done, m_data);
            end
            if (bus_we_n !== 1'b1 || bus_rnw !== 1'b1) begin
                ok = 0; $display("FAIL R11 we_n/rnw: actual %0b%0b expected 11", bus_we_n, bus_rnw);
            end
            n_chk++;
            if (!ok) n_fail++;
        end
    end

    // one read; latency and trail length checked against R3/R6/R9 formulas
    task automatic do_read(input int z, input logic [AW-1:0] a,
                           input bit pre_rdy, input int rdy_at, input string tag);
        int k, align, nominal, exp_lat, j;
        bus_ready = pre_rdy;
        repeat (3) @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_zone = 2'(z); req_addr = a;
        align = (half_rate && bus_clk) ? 1 : 0;
        @(negedge clk);
        req_valid = 1'b0;
        if (align == 1)
            check(bus_cs_n === '1 && bus_rd_n === 1'b1, "R6", {tag, " align quiet"}, bus_cs_n, 4'hF);
        k = 1;
        while (!done && k < 80) begin
            if (k == rdy_at) bus_ready = 1'b1;
            @(negedge clk);
            k++;
        end
        nominal = align + plen(zone_lead, z) + plen(zone_active, z);
        exp_lat = ((rdy_at > 0 && rdy_at + 2 > nominal) ? rdy_at + 2 : nominal) + 1;
        check(k == exp_lat, "R3", {tag, " done latency (R6 R9)"}, k, exp_lat);
        check(done_data === mem_word(a), "R10", {tag, " data"}, done_data, mem_word(a));
        j = 0;
        while (!req_ready && j < 20) begin @(negedge clk); j++; end
        check(j == plen(zone_trail, z), "R3", {tag, " trail length"}, j, plen(zone_trail, z));
        bus_ready = 1'b1;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1, "R1", "reset req_ready", req_ready, 1);
        check(bus_cs_n === '1 && bus_rd_n === 1'b1, "R1", "reset strobes", {bus_cs_n, bus_rd_n}, 5'h1F);
        check(bus_addr === '0, "R1", "reset addr", bus_addr, 0);

        // full rate, several zones
        do_read(0, 19'h00123, 1, 0, "z0 full");
        do_read(1, 19'h7ABCD, 1, 0, "z1 full");
        do_read(2, 19'h40001, 1, 0, "z2 zero fields");
        do_read(0, 19'h7FFFF, 1, 0, "z0 max addr");
        // R7 address held while idle
        repeat (3) @(negedge clk);
        check(bus_addr === 19'h7FFFF, "R7", "idle hold", bus_addr, 19'h7FFFF);

        // R8 ready ignored when disabled
        do_read(1, 19'h05555, 0, 0, "z1 ready ignored R8");

        // R9 ready used
        do_read(3, 19'h12345, 1, 0, "z3 ready high");
        do_read(3, 19'h23456, 0, 2, "z3 ready early");
        do_read(3, 19'h34567, 0, 4, "z3 one extension");
        do_read(3, 19'h45678, 0, 9, "z3 long wait");

        // half rate, both alignment positions
        half_rate = 1'b1;
        for (int i = 0; i < 6; i++) begin
            do_read(i % 3, 19'(20'h1000 + i * 20'h111), 1, 0, "half rate R5");
            if (i % 2 == 1) @(negedge clk);
        end
        do_read(3, 19'h6789A, 0, 6, "half rate ready");
        half_rate = 1'b0;
        do_read(1, 19'h00F0F, 1, 0, "back to full");

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule